// File: doc/BRIEF.md
# Pseudo-Static RAM Access and Refresh Controller

This block sits between a simple host port and a 128K x 8 pseudo-static RAM. The RAM's address bus is not multiplexed, and the RAM captures the address when chip enable falls. The controller turns each accepted host request into one access cycle. It places the address one cycle early, holds chip enable low for a fixed number of clocks, then holds it high for a precharge interval.

A write keeps the data driver on for the whole low phase. R/W is pulsed low and released one cycle before chip enable rises, so the RAM stores the word on the rising R/W edge. A read drives output enable low while the data driver is off. The returned byte is captured on the last low cycle.

A refresh interval timer raises a pending flag. The sequencer answers the flag with an auto-refresh pulse on the refresh pin as soon as the bus is idle. The host can also ask for a low-power self-refresh state, in which the refresh pin is held low. On leaving that state, a recovery delay is observed before the next access. Every timing figure is a parameter counted in clock cycles.

Top module: `psram_ctrl`

## Requirements
- R1: After synchronous reset, chip enable and the refresh pin are high (inactive), the data driver is off, `sleep_ack` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A word written to any address in 0 to 0x1FFFF is returned by a later read of that address, including both ends of the range.
- R3: `mem_addr` is stable during the cycle before chip enable falls and during every cycle that chip enable is low.
- R4: Each chip-enable low phase lasts exactly `CE_LOW` cycles, and chip enable stays high for at least `PRECH` cycles between two low phases.
- R5: The data driver (`mem_dq_oe` = 1) is never enabled while output enable is low.
- R6: In a write, R/W is low from the first cycle that chip enable is low. R/W rises one cycle before chip enable rises, and the data driver is still enabled at that rising edge.
- R7: An auto-refresh pulse holds the refresh pin low for `RF_LOW` cycles while chip enable is high. It is followed by at least `RF_HIGH` cycles of the refresh pin high before any other pin activity.
- R8: Outside self refresh, consecutive auto-refresh pulses start at most `REF_INTERVAL + CE_LOW + PRECH + 2` cycles apart.
- R9: While a refresh is pending, `req_ready` is 0. The refresh is issued before any new host access.
- R10: On `sleep_req`, the refresh pin goes low and stays low for at least `SR_MIN` cycles before `sleep_ack` rises. The pin stays low until `sleep_req` drops. Chip enable then stays high for at least `SR_EXIT` cycles after the refresh pin rises.
- R11: While in self refresh, `req_ready` is 0, host requests are ignored, and chip enable stays high.
- R12: `rsp_valid` pulses for one cycle, `1 + CE_LOW` cycles after the clock edge that accepts a read. `rsp_rdata` holds the byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Request accepted on a clock edge where valid and ready are both 1 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 8 | Read byte |
| sleep_req | input | 1 | Request self-refresh state |
| sleep_ack | output | 1 | Self-refresh state reached |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_cs | output | 1 | RAM chip select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_rw_n | output | 1 | RAM R/W (low = write) |
| mem_rfsh_n | output | 1 | RAM refresh pin, active low |
| mem_dq_out | output | 8 | Data to RAM |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 8 | Data from RAM |

## Verification
The bench builds the controller with these cycle counts: `CE_LOW`=4, `PRECH`=2, `RF_LOW`=2, `RF_HIGH`=3, `SR_MIN`=12, `SR_EXIT`=5 and `REF_INTERVAL`=60. With these values several auto-refresh pulses fall between host accesses within a few hundred cycles, so collisions between pending refresh and host traffic occur often. A full self-refresh entry and exit also fits in a short run. A bench-side RAM model watches the pins for address stability, phase widths, bus contention, refresh spacing and recovery delay. The same model stores and returns data, so read-back proves the whole write and read path.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_PRECH,
        ST_RF_LO,
        ST_RF_HI,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_EXIT
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_req_t;

    typedef struct packed {
        logic ce_n;
        logic cs;
        logic oe_n;
        logic rw_n;
        logic rfsh_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_IDLE = '{ce_n: 1'b1, cs: 1'b0, oe_n: 1'b1,
                                       rw_n: 1'b1, rfsh_n: 1'b1, dq_oe: 1'b0};

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_rfsh_timer.sv
module psram_rfsh_timer #(
    parameter int REF_INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic ack,
    output logic pend
);
    localparam int TW = $clog2(REF_INTERVAL + 1);

    logic [TW-1:0] tick;
    logic          wrap;

    assign wrap = (tick == TW'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            tick <= '0;
            pend <= 1'b0;
        end else begin
            tick <= wrap ? '0 : tick + 1'b1;
            if (wrap)
                pend <= 1'b1;
            else if (ack)
                pend <= 1'b0;
        end
    end

    // R8
    pend_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap && !hold) |=> pend);

endmodule

// File: rtl/psram_seq.sv
module psram_seq
    import psram_pkg::*;
#(
    parameter int CE_LOW  = 9,
    parameter int PRECH   = 4,
    parameter int RF_LOW  = 3,
    parameter int RF_HIGH = 10,
    parameter int SR_MIN  = 800,
    parameter int SR_EXIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  host_req_t         req,
    output logic              req_ready,
    input  logic              rf_pend,
    output logic              rf_ack,
    input  logic              sleep_req,
    output logic              sleep_ack,
    output logic              sr_active,
    output pin_ctl_t          ctl,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int CMAX = max_of(max_of(max_of(CE_LOW, PRECH), max_of(RF_LOW, RF_HIGH)),
                                 max_of(SR_MIN, SR_EXIT));
    localparam int CW = $clog2(CMAX + 1);

    seq_state_e state;
    logic [CW-1:0] cnt;
    host_req_t cur;
    logic last;

    assign last      = (cnt == '0);
    assign req_ready = (state == ST_IDLE) && !rf_pend && !sleep_req;
    assign rf_ack    = (state == ST_IDLE) && rf_pend;
    assign sleep_ack = (state == ST_SR_HOLD);
    assign sr_active = (state == ST_SR_ENTER) || (state == ST_SR_HOLD) || (state == ST_SR_EXIT);
    assign mem_addr  = cur.addr;
    assign mem_wdata = cur.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cur       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            cnt       <= last ? '0 : cnt - 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (rf_pend) begin
                        state <= ST_RF_LO;
                        cnt   <= CW'(RF_LOW - 1);
                    end else if (sleep_req) begin
                        state <= ST_SR_ENTER;
                        cnt   <= CW'(SR_MIN - 1);
                    end else if (req_valid) begin
                        cur   <= req;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    state <= ST_ACTIVE;
                    cnt   <= CW'(CE_LOW - 1);
                end
                ST_ACTIVE: if (last) begin
                    state <= ST_PRECH;
                    cnt   <= CW'(PRECH - 1);
                    if (!cur.write) begin
                        rsp_valid <= 1'b1;
                        rsp_rdata <= mem_rdata;
                    end
                end
                ST_PRECH:    if (last) state <= ST_IDLE;
                ST_RF_LO: if (last) begin
                    state <= ST_RF_HI;
                    cnt   <= CW'(RF_HIGH - 1);
                end
                ST_RF_HI:    if (last) state <= ST_IDLE;
                ST_SR_ENTER: if (last) state <= ST_SR_HOLD;
                ST_SR_HOLD: if (!sleep_req) begin
                    state <= ST_SR_EXIT;
                    cnt   <= CW'(SR_EXIT - 1);
                end
                ST_SR_EXIT:  if (last) state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl = PINS_IDLE;
        unique case (state)
            ST_SETUP, ST_PRECH: ctl.cs = 1'b1;
            ST_ACTIVE: begin
                ctl.cs   = 1'b1;
                ctl.ce_n = 1'b0;
                if (cur.write) begin
                    ctl.rw_n  = last;
                    ctl.dq_oe = 1'b1;
                end else begin
                    ctl.oe_n = 1'b0;
                end
            end
            ST_RF_LO, ST_SR_ENTER, ST_SR_HOLD: ctl.rfsh_n = 1'b0;
            default: ;
        endcase
    end

    // R5
    no_bus_fight_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.dq_oe && !ctl.oe_n));
    // R7
    refresh_ce_high_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.rfsh_n |-> ctl.ce_n);
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.ce_n |-> $stable(mem_addr));
    // R4
    ce_min_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.ce_n) |=> !ctl.ce_n);
    // R10
    sleep_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_ack) |-> $past(!ctl.rfsh_n));

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int CE_LOW       = 9,
    parameter int PRECH        = 4,
    parameter int RF_LOW       = 3,
    parameter int RF_HIGH      = 10,
    parameter int SR_MIN       = 800,
    parameter int SR_EXIT      = 16,
    parameter int REF_INTERVAL = 1560
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              sleep_req,
    output logic              sleep_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_cs,
    output logic              mem_oe_n,
    output logic              mem_rw_n,
    output logic              mem_rfsh_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic      rf_pend;
    logic      rf_ack;
    logic      sr_active;
    pin_ctl_t  ctl;
    host_req_t req;

    assign req = '{write: req_write, addr: req_addr, data: req_wdata};

    psram_rfsh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (sr_active),
        .ack  (rf_ack),
        .pend (rf_pend)
    );

    psram_seq #(
        .CE_LOW(CE_LOW), .PRECH(PRECH), .RF_LOW(RF_LOW),
        .RF_HIGH(RF_HIGH), .SR_MIN(SR_MIN), .SR_EXIT(SR_EXIT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req       (req),
        .req_ready (req_ready),
        .rf_pend   (rf_pend),
        .rf_ack    (rf_ack),
        .sleep_req (sleep_req),
        .sleep_ack (sleep_ack),
        .sr_active (sr_active),
        .ctl       (ctl),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_dq_out),
        .mem_rdata (mem_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_ce_n   = ctl.ce_n;
    assign mem_cs     = ctl.cs;
    assign mem_oe_n   = ctl.oe_n;
    assign mem_rw_n   = ctl.rw_n;
    assign mem_rfsh_n = ctl.rfsh_n;
    assign mem_dq_oe  = ctl.dq_oe;

    // R9
    refresh_first_chk: assert property (@(posedge clk) disable iff (rst)
        rf_pend |-> !req_ready);
    // R11
    sleep_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |-> (!req_ready && mem_ce_n));

endmodule

// File: tb/psram_ctrl_test.sv
module psram_ctrl_test;
    localparam int CLK_PERIOD   = 10;
    localparam int P_CE_LOW     = 4;
    localparam int P_PRECH      = 2;
    localparam int P_RF_LOW     = 2;
    localparam int P_RF_HIGH    = 3;
    localparam int P_SR_MIN     = 12;
    localparam int P_SR_EXIT    = 5;
    localparam int P_INTERVAL   = 60;
    localparam int RF_GAP_MAX   = P_INTERVAL + P_CE_LOW + P_PRECH + 2;
    localparam int CE_LOW_MAX   = 1000;

    // vector: {write, addr[16:0], data[7:0]}
    localparam int NVEC = 10;
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b1, 17'h00000, 8'hA5},
        {1'b1, 17'h1FFFF, 8'h3C},
        {1'b1, 17'h12345, 8'h7E},
        {1'b1, 17'h0ABCD, 8'h01},
        {1'b1, 17'h10000, 8'hFF},
        {1'b0, 17'h00000, 8'hA5},
        {1'b0, 17'h1FFFF, 8'h3C},
        {1'b0, 17'h12345, 8'h7E},
        {1'b0, 17'h0ABCD, 8'h01},
        {1'b0, 17'h10000, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        sleep_req = 1'b0;
    logic        sleep_ack;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_cs, mem_oe_n, mem_rw_n, mem_rfsh_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int wd      = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_ctrl #(
        .CE_LOW(P_CE_LOW), .PRECH(P_PRECH), .RF_LOW(P_RF_LOW), .RF_HIGH(P_RF_HIGH),
        .SR_MIN(P_SR_MIN), .SR_EXIT(P_SR_EXIT), .REF_INTERVAL(P_INTERVAL)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sleep_req(sleep_req),
        .sleep_ack(sleep_ack), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_rw_n(mem_rw_n),
        .mem_rfsh_n(mem_rfsh_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural RAM model and pin monitor ----------------
    logic [7:0]  model_mem [int];
    logic        p_ce = 1'b1, p_rw = 1'b1, p_rf = 1'b1;
    logic [16:0] p_addr = '0, lat_addr = '0;
    int ce_lo = 0, ce_hi = 1000, rf_lo = 0, since_sr = 1000;
    int cyc = 0, rf_fall_at = 0, last_rf = -1, auto_rf_n = 0;

    always @(negedge clk) begin
        if (rst) begin
            p_ce = 1'b1; p_rw = 1'b1; p_rf = 1'b1; ce_hi = 1000; since_sr = 1000; last_rf = -1;
        end else begin
            cyc++;
            since_sr++;
            if (!mem_oe_n) chk(!mem_dq_oe, "R5 driver off under OE", int'(mem_dq_oe), 0);
            if (!mem_ce_n && !p_ce) chk(mem_addr == p_addr, "R3 addr held", int'(mem_addr), int'(p_addr));
            if (!mem_ce_n && p_ce) begin
                chk(mem_addr == p_addr, "R3 addr setup", int'(mem_addr), int'(p_addr));
                chk(ce_hi >= P_PRECH, "R4 precharge", ce_hi, P_PRECH);
                chk(since_sr >= P_SR_EXIT, "R10 exit recovery", since_sr, P_SR_EXIT);
                chk(mem_rw_n == 1'b1 || mem_dq_oe, "R6 driver with RW low", int'(mem_dq_oe), 1);
                lat_addr = mem_addr;
                ce_lo = 0;
            end
            if (mem_ce_n && !p_ce) begin
                chk(ce_lo == P_CE_LOW && ce_lo <= CE_LOW_MAX, "R4 CE low width", ce_lo, P_CE_LOW);
                chk(p_rw == 1'b1, "R6 RW up before CE", int'(p_rw), 1);
                ce_hi = 0;
            end
            if (!mem_ce_n && !p_ce && mem_rw_n && !p_rw) begin
                chk(mem_dq_oe == 1'b1, "R6 data driven at RW rise", int'(mem_dq_oe), 1);
                model_mem[int'(lat_addr)] = mem_dq_out;
            end
            if (!mem_rfsh_n) chk(mem_ce_n == 1'b1, "R7 CE high in refresh", int'(mem_ce_n), 1);
            if (!mem_rfsh_n && p_rf) begin
                rf_lo = 0;
                rf_fall_at = cyc;
            end
            if (mem_rfsh_n && !p_rf) begin
                if (rf_lo >= P_SR_MIN) begin
                    since_sr = 0;
                    last_rf = -1;
                end else begin
                    chk(rf_lo == P_RF_LOW, "R7 refresh low width", rf_lo, P_RF_LOW);
                    if (last_rf >= 0)
                        chk(rf_fall_at - last_rf <= RF_GAP_MAX, "R8 refresh spacing",
                            rf_fall_at - last_rf, RF_GAP_MAX);
                    last_rf = rf_fall_at;
                    auto_rf_n++;
                end
                ce_hi = 0;
            end
            if (!mem_ce_n) ce_lo++; else ce_hi++;
            if (!mem_rfsh_n) rf_lo++;
            if (!mem_ce_n && !mem_oe_n && mem_rw_n)
                mem_dq_in <= model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'hEE;
            else
                mem_dq_in <= 8'h00;
            p_ce = mem_ce_n; p_rw = mem_rw_n; p_rf = mem_rfsh_n; p_addr = mem_addr;
        end
    end

    // R7: refresh recovery, no CE fall within RF_HIGH cycles after pin rises
    always @(negedge clk) begin
        if (!rst && !mem_ce_n && p_ce && ce_hi < P_RF_HIGH)
            chk(1'b0, "R7 refresh recovery", ce_hi, P_RF_HIGH);
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            chk(1'b0, "watchdog", wd, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic access(input logic wr, input logic [16:0] a, input logic [7:0] d,
                          output logic [7:0] q, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        q = '0;
        if (!wr) begin
            while (!rsp_valid && lat < 100) begin
                @(negedge clk);
                lat++;
            end
            q = rsp_rdata;
        end
    endtask

    initial begin
        logic [7:0] q;
        int lat;
        int lo;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce_n == 1'b1, "R1 ce_n", int'(mem_ce_n), 1);
        chk(mem_rfsh_n == 1'b1, "R1 rfsh_n", int'(mem_rfsh_n), 1);
        chk(mem_dq_oe == 1'b0, "R1 dq_oe", int'(mem_dq_oe), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(!sleep_ack && !rsp_valid, "R1 ack/rsp", int'(sleep_ack), 0);

        // vector table: writes then read-back (R2, R12)
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][25], VEC[i][24:8], VEC[i][7:0], q, lat);
            if (!VEC[i][25]) begin
                chk(q == VEC[i][7:0], "R2 read-back", int'(q), int'(VEC[i][7:0]));
                chk(lat == 1 + P_CE_LOW, "R12 read latency", lat, 1 + P_CE_LOW);
            end
        end

        // R9: ready low while a refresh is under way
        lo = 0;
        while (mem_rfsh_n && lo < 500) begin @(negedge clk); lo++; end
        chk(!mem_rfsh_n, "R9 refresh seen", int'(mem_rfsh_n), 0);
        while (!mem_rfsh_n) begin
            chk(!req_ready, "R9 ready held low", int'(req_ready), 0);
            @(negedge clk);
        end
        access(1'b1, 17'h00042, 8'h5A, q, lat);
        access(1'b0, 17'h00042, 8'h00, q, lat);
        chk(q == 8'h5A, "R9 access after refresh", int'(q), 8'h5A);

        // R8: idle stretch produces regular refresh pulses
        lo = auto_rf_n;
        repeat (6 * P_INTERVAL) @(negedge clk);
        chk(auto_rf_n - lo >= 5, "R8 refresh count", auto_rf_n - lo, 5);

        // R10/R11: self refresh
        @(negedge clk);
        sleep_req = 1'b1;
        lo = 0;
        while (!sleep_ack && lo < 1000) begin
            @(negedge clk);
            if (!mem_rfsh_n) lo++;
        end
        chk(lo >= P_SR_MIN, "R10 low before ack", lo, P_SR_MIN);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00000; req_wdata = 8'h99;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk(!req_ready && mem_ce_n, "R11 request ignored", int'(mem_ce_n), 1);
        end
        req_valid = 1'b0;
        chk(!mem_rfsh_n, "R10 pin held low", int'(mem_rfsh_n), 0);
        sleep_req = 1'b0;
        access(1'b0, 17'h00000, 8'h00, q, lat);
        chk(q == 8'hA5, "R11 data untouched", int'(q), 8'hA5);
        access(1'b0, 17'h1FFFF, 8'h00, q, lat);
        chk(q == 8'h3C, "R2 top address after wake", int'(q), 8'h3C);
        repeat (10) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule